// File: doc/BRIEF.md
# Serial Wire Debug Host Engine

This block is the host end of a two-wire debug link. A single start strobe makes it run one complete transaction on the link, built from the fields given with the strobe: a port-select bit, a read/write flag, a 2-bit register address and a 32-bit write word. The link clock is derived from the system clock through a divider. The shared data line is split into separate output, output-enable and input signals, so that a pad cell or a tristate buffer can be placed outside the block.

A transaction moves through the header, a released-line turnaround, the 3-bit target response and, when the response is OK, a 32-bit data word with parity in either direction. When the transaction ends the block pulses done. It reports the response code, the read word and a flag that marks a read parity mismatch. Between transactions the clock rests low and the data line is driven low.

Top module: `swd_host_engine`

## Requirements
- R1: Out of reset and whenever no transaction is running, swclk is 0, swdio_oe is 1, swdio_o is 0, busy is 0 and done is 0.
- R2: swclk has a period of 2*HALF_DIV system clocks. Each bit slot begins with HALF_DIV clocks low, then HALF_DIV clocks high. Host outputs change only when swclk falls. Target input is captured at the system edge on which swclk rises.
- R3: A start strobe while idle starts a transaction on the next clock. Eight header slots are driven in this order: 1, apndp, rnw, addr[0], addr[1], even parity of those four bits, 0, 1.
- R4: After the header there is one slot with swdio_oe low. Three response slots with swdio_oe low follow, and the response is stored LSB first into ack.
- R5: If ack is 3'b001 and rnw is 0, one turnaround slot with swdio_oe low follows. The block then drives wdata LSB first over 32 slots and their even parity in one more slot.
- R6: If ack is 3'b001 and rnw is 1, the block samples 32 data slots LSB first into rdata and one parity slot, all with swdio_oe low. One turnaround slot follows.
- R7: perr is set when the received parity bit differs from the even parity of the 32 received bits. rdata still shows the received word.
- R8: For any ack other than 3'b001, the data slots are skipped. One turnaround slot is followed by done, with ack reported and rdata left at 0.
- R9: A start strobe while busy is 1 is ignored and leaves the running transaction unchanged.
- R10: done is high for exactly one system clock, at the end of the last slot. On that same clock the line returns to the idle state of R1. ack, rdata and perr stay valid until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one transaction |
| apndp | input | 1 | Port select bit of the header |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Register address bits (A[2] in bit 0, A[3] in bit 1) |
| wdata | input | 32 | Word to write |
| swdio_i | input | 1 | Data line as seen at the pin |
| swclk | output | 1 | Link clock |
| swdio_o | output | 1 | Data line value to drive |
| swdio_oe | output | 1 | 1 = host drives the data line |
| rdata | output | 32 | Word received on a read |
| ack | output | 3 | Target response, LSB received first |
| perr | output | 1 | Read parity mismatch |
| done | output | 1 | One-clock end-of-transaction pulse |
| busy | output | 1 | Transaction in progress |

## Verification
Let k be the number of system clocks after the edge that accepts start. Slot s then covers k from 2*HALF_DIV*s to 2*HALF_DIV*(s+1)-1, and swclk is high in the second half of that range. done, the return to idle and the final ack, rdata and perr are due at k = 2*HALF_DIV*N, where N is 13 for a rejected response and 46 for a completed data phase. The bench builds a per-slot list of expected drive values and target replies. At every falling system edge it compares swclk, swdio_oe, swdio_o (when driven), busy and done against the slot derived from k. It feeds the target bit one clock before the rising swclk that captures it.

// File: rtl/swd_host_engine.sv
module swd_host_engine #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        apndp,
  input  logic        rnw,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  input  logic        swdio_i,
  output logic        swclk,
  output logic        swdio_o,
  output logic        swdio_oe,
  output logic [31:0] rdata,
  output logic [2:0]  ack,
  output logic        perr,
  output logic        done,
  output logic        busy
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);
  localparam logic [2:0] ACK_OK = 3'b001;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_TRN1, S_ACK, S_WDAT, S_RDAT, S_TRN2} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [5:0]    bitn;
  logic [7:0]    hdr;
  logic [31:0]   wsh;
  logic          wpar, rnw_q, rpar;

  assign busy = (st != S_IDLE);

  logic tick, rise, fall;
  assign tick = busy && (cnt == CNT_LAST);
  assign rise = tick && !swclk;
  assign fall = tick && swclk;

  assign swdio_oe = (st == S_IDLE) || (st == S_REQ) || (st == S_WDAT);
  assign swdio_o  = (st == S_REQ)  ? hdr[bitn[2:0]] :
                    (st == S_WDAT) ? (bitn[5] ? wpar : wsh[0]) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      hdr   <= '0;
      wsh   <= '0;
      wpar  <= 1'b0;
      rnw_q <= 1'b0;
      rpar  <= 1'b0;
      swclk <= 1'b0;
      rdata <= '0;
      ack   <= '0;
      perr  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          st    <= S_REQ;
          cnt   <= '0;
          bitn  <= '0;
          hdr   <= {1'b1, 1'b0, ^{apndp, rnw, addr}, addr[1], addr[0], rnw, apndp, 1'b1};
          wsh   <= wdata;
          wpar  <= ^wdata;
          rnw_q <= rnw;
          rdata <= '0;
          ack   <= '0;
          perr  <= 1'b0;
        end
      end else begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) swclk <= !swclk;
        if (rise) begin
          if (st == S_ACK) ack[bitn[1:0]] <= swdio_i;
          if (st == S_RDAT) begin
            if (bitn[5]) rpar <= swdio_i;
            else         rdata[bitn[4:0]] <= swdio_i;
          end
        end
        if (fall) begin
          case (st)
            S_REQ: begin
              if (bitn == 6'd7) begin
                st   <= S_TRN1;
                bitn <= '0;
              end else bitn <= bitn + 1'b1;
            end
            S_TRN1: begin
              st   <= S_ACK;
              bitn <= '0;
            end
            S_ACK: begin
              if (bitn == 6'd2) begin
                bitn <= '0;
                st   <= (ack == ACK_OK && rnw_q) ? S_RDAT : S_TRN2;
              end else bitn <= bitn + 1'b1;
            end
            S_WDAT: begin
              if (bitn == 6'd32) begin
                st   <= S_IDLE;
                done <= 1'b1;
              end else begin
                bitn <= bitn + 1'b1;
                wsh  <= wsh >> 1;
              end
            end
            S_RDAT: begin
              if (bitn == 6'd32) begin
                perr <= (^rdata) != rpar;
                st   <= S_TRN2;
                bitn <= '0;
              end else bitn <= bitn + 1'b1;
            end
            S_TRN2: begin
              if (ack == ACK_OK && !rnw_q) begin
                st   <= S_WDAT;
                bitn <= '0;
              end else begin
                st   <= S_IDLE;
                done <= 1'b1;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/swd_host_engine_chk.sv
module swd_host_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic swclk,
  input logic swdio_o,
  input logic swdio_oe,
  input logic done,
  input logic busy
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!swclk && swdio_oe && !swdio_o));

  // R2
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(swdio_o)) |-> $fell(swclk));

  // R4
  oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(swdio_oe)) |-> $fell(swclk));

  // R3
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && swdio_oe && swdio_o && !swclk));

endmodule

bind swd_host_engine swd_host_engine_chk chk (
  .clk(clk), .rst_n(rst_n), .start(start), .swclk(swclk),
  .swdio_o(swdio_o), .swdio_oe(swdio_oe), .done(done), .busy(busy)
);

// File: tb/swd_host_engine_test.sv
module swd_host_engine_test;

  localparam int H  = 3;
  localparam int SP = 2 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, apndp = 1'b0, rnw = 1'b0, swdio_i = 1'b1;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic swclk, swdio_o, swdio_oe, perr, done, busy;
  logic [31:0] rdata;
  logic [2:0]  ack;

  int tests = 0, fails = 0, cyc = 0;
  logic e_oe [64];
  logic e_o  [64];
  logic t_v  [64];
  int   nslot;

  always #2.5 clk = ~clk;

  swd_host_engine #(.HALF_DIV(H)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .apndp(apndp), .rnw(rnw),
    .addr(addr), .wdata(wdata), .swdio_i(swdio_i), .swclk(swclk),
    .swdio_o(swdio_o), .swdio_oe(swdio_oe), .rdata(rdata), .ack(ack),
    .perr(perr), .done(done), .busy(busy)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected below 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic push(input logic oe, input logic o, input logic t);
    e_oe[nslot] = oe; e_o[nslot] = o; t_v[nslot] = t; nslot++;
  endtask

  task automatic run_txn(input logic ap, input logic rw, input logic [1:0] a,
                         input logic [31:0] wd, input logic [2:0] ackv,
                         input logic [31:0] rd, input bit flip, input int poke,
                         input string tag);
    bit ok;
    logic [4:0] got, expv;
    nslot = 0;
    push(1, 1, 1); push(1, ap, 1); push(1, rw, 1); push(1, a[0], 1); push(1, a[1], 1);
    push(1, ap ^ rw ^ a[0] ^ a[1], 1); push(1, 0, 1); push(1, 1, 1);
    push(0, 0, 1);
    for (int i = 0; i < 3; i++) push(0, 0, ackv[i]);
    ok = (ackv == 3'b001);
    if (!ok) push(0, 0, 1);
    else if (!rw) begin
      push(0, 0, 1);
      for (int i = 0; i < 32; i++) push(1, wd[i], 1);
      push(1, ^wd, 1);
    end else begin
      for (int i = 0; i < 32; i++) push(0, 0, rd[i]);
      push(0, 0, (^rd) ^ flip);
      push(0, 0, 1);
    end

    @(negedge clk);
    apndp = ap; rnw = rw; addr = a; wdata = wd; start = 1'b1;
    for (int k = 0; k <= nslot * SP + 1; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (k == poke) begin
        start = 1'b1; apndp = ~ap; rnw = ~rw; addr = ~a; wdata = ~wd;
      end
      if (k == poke + 1) start = 1'b0;
      swdio_i = (k / SP < nslot) ? t_v[k / SP] : 1'b1;
      got = {swclk, swdio_oe, swdio_o, busy, done};
      if (k < nslot * SP) begin
        expv = {((k % SP) >= H) ? 1'b1 : 1'b0, e_oe[k / SP], e_o[k / SP], 1'b1, 1'b0};
        if (!e_oe[k / SP]) begin expv[2] = 1'b0; got[2] = 1'b0; end
        check(got == expv, {tag, " R2 slot"}, 32'(got), 32'(expv));
      end else if (k == nslot * SP) begin
        check(got == 5'b01001, {tag, " R10 done"}, 32'(got), 32'h9);
        check(ack == ackv, {tag, " R4 ack"}, 32'(ack), 32'(ackv));
        check(rdata == ((ok && rw) ? rd : 32'h0), {tag, " R6 rdata"}, rdata, (ok && rw) ? rd : 32'h0);
        check(perr == (ok && rw && flip), {tag, " R7 perr"}, 32'(perr), 32'(ok && rw && flip));
      end else begin
        check(got == 5'b01000, {tag, " R10 idle after done"}, 32'(got), 32'h8);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({swclk, swdio_oe, swdio_o, busy, done} == 5'b01000, "R1 reset",
          32'({swclk, swdio_oe, swdio_o, busy, done}), 32'h8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({swclk, swdio_oe, swdio_o, busy, done} == 5'b01000, "R1 idle",
          32'({swclk, swdio_oe, swdio_o, busy, done}), 32'h8);
    run_txn(0, 0, 2'b01, 32'hA5F0_1234, 3'b001, 32'h0, 0, -5, "R3 R5 write");
    run_txn(1, 0, 2'b11, 32'hFFFF_FFFF, 3'b001, 32'h0, 0, -5, "R3 R5 write ones");
    run_txn(1, 1, 2'b10, 32'h0, 3'b001, 32'h8000_0001, 0, -5, "R6 read");
    run_txn(0, 1, 2'b00, 32'h0, 3'b001, 32'h1357_9BDF, 1, -5, "R7 read bad parity");
    run_txn(0, 1, 2'b01, 32'h0, 3'b010, 32'hDEAD_BEEF, 0, -5, "R8 read wait");
    run_txn(1, 0, 2'b10, 32'h1111_2222, 3'b100, 32'h0, 0, -5, "R8 write fault");
    run_txn(1, 1, 2'b11, 32'h0, 3'b111, 32'h0, 0, -5, "R8 read no response");
    run_txn(0, 0, 2'b10, 32'h0F0F_3C3C, 3'b001, 32'h0, 0, 40, "R9 start while busy");
    run_txn(1, 1, 2'b01, 32'h0, 3'b001, 32'h7FFF_0000, 0, 200, "R9 start late in read");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule